// File: doc/BRIEF.md
# SDRAM Mode-Register Command Issuer

This block sits inside a memory controller and owns the mode word that is loaded into the SDRAM devices of two partition pairs. Software writes one 32-bit configuration word. The word carries an 8-bit user mode value for each pair. Each write starts a command sequence. The sequence waits until the bank tracker reports every bank precharged and idle. It then places one single-cycle Mode Register Set command on the bus for pair 0, followed by one for pair 2.

The address carried by each command has two parts. The pair's user value sits in the high bits. Hardwired burst fields and a CAS-latency code taken from the pair's timing bit sit in the low bits. Chip selects are driven only for banks that are enabled. A `busy_o` level and a one-cycle `done_o` pulse let the requester know when the sequence has finished. A write that lands mid-sequence is held pending and replayed with the new values.

Top module: `sdram_mrs_issuer`

## Requirements
- R1: After reset, with both timing bits 0, `reg_rdata_o` reads 0x0022_0022; `busy_o`, `done_o` are 0, all chip selects and `ras_n_o`/`cas_n_o`/`sdram_we_n_o` are high.
- R2: A write stores bits 30:23 as the pair-2 user value and bits 14:7 as the pair-0 user value; both read back at the same positions.
- R3: Write data in bits 31, 22:16, 15 and 6:0 is ignored: bits 31 and 15 read 0, bits 19 and 3 (burst type) read 0, bits 18:16 and 2:0 (burst length) read 010.
- R4: The CAS-latency field (bits 22:20 for pair 2, 6:4 for pair 0) reads 010 when the pair's timing bit is 0 and 011 when it is 1; `timing_cl_i[0]` serves pair 0 and `timing_cl_i[1]` serves pair 2.
- R5: Each accepted write yields exactly two commands, pair 0 first and then pair 2. Each command lasts one cycle with `ras_n_o`, `cas_n_o` and `sdram_we_n_o` all low.
- R6: A command is placed on the bus only if `banks_idle_i` was high in the preceding cycle; while it stays low the sequence waits with `busy_o` high.
- R7: During a pair's command, `ma_o[24:17]` is the user value, `ma_o[16:14]` the CAS-latency code of R4, `ma_o[13]` is 0, `ma_o[12:10]` is 010 and `ma_o[9:0]` is 0.
- R8: During pair p's command (p=0 for pair 0, p=1 for pair 2), `cs_n_o[2p+k]` is low only if `bank_en_i[2p+k]` is 1. Disabled banks keep their select high, so a write made with the banks disabled selects no device.
- R9: `busy_o` is high from the cycle after a write until the sequence ends. `done_o` pulses for one cycle after the pair-2 command, and `busy_o` is low in that cycle unless a write is pending.
- R10: A write made while busy is held pending. After the running sequence completes, a second two-command sequence runs carrying the newly written user values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Configuration word write strobe |
| reg_wdata_i | input | 32 | Configuration write data |
| reg_rdata_o | output | 32 | Configuration readback |
| timing_cl_i | input | 2 | Per-pair CAS timing bit (bit 0 pair 0, bit 1 pair 2) |
| bank_en_i | input | 4 | Bank enables, two per pair |
| banks_idle_i | input | 1 | All banks precharged and idle |
| ma_o | output | 25 | SDRAM address bus |
| cs_n_o | output | 4 | Active-low chip selects |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |
| sdram_we_n_o | output | 1 | Active-low write enable |
| busy_o | output | 1 | Command sequence outstanding |
| done_o | output | 1 | One-cycle sequence completion pulse |

## Verification
A corrupted user register appears at once on `reg_rdata_o`, and again in `ma_o[24:17]` during the next command. A wrong CAS-latency mapping shows in both places at the same time. A sequencer that skips its wait, loses a pending write or repeats a pair shows up within a few cycles of the write. It changes the number of low-strobe cycles seen before `done_o`, or their pair order. A wrong chip-select snapshot is visible during the single command cycle of the affected pair.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  localparam int CL_W   = 3;
  localparam int MODE_W = 7;  // CL + burst type + burst length

  localparam logic [2:0] BL_FOUR  = 3'b010;
  localparam logic       BT_SEQ   = 1'b0;
  localparam logic [2:0] CL_SHORT = 3'b010;
  localparam logic [2:0] CL_LONG  = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_DONE
  } seq_state_e;

  function automatic logic [CL_W-1:0] cl_code(input logic timing_bit);
    return timing_bit ? CL_LONG : CL_SHORT;
  endfunction

endpackage

// File: rtl/mrs_cfg_regs.sv
module mrs_cfg_regs
  import sdram_mrs_pkg::*;
#(
  parameter int NUM_PAIRS   = 2,
  parameter int USER_W      = 8,
  parameter int PAIR_STRIDE = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [NUM_PAIRS*PAIR_STRIDE-1:0] wdata_i,
  input  logic [NUM_PAIRS-1:0]             timing_cl_i,
  output logic [NUM_PAIRS*USER_W-1:0]      user_o,
  output logic [NUM_PAIRS*PAIR_STRIDE-1:0] rdata_o
);

  localparam int FIELD_W = USER_W + MODE_W;
  localparam int PAD_W   = PAIR_STRIDE - FIELD_W;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int BASE = p * PAIR_STRIDE;
    logic [USER_W-1:0] user_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   user_q <= '0;
      else if (we_i) user_q <= wdata_i[BASE+MODE_W +: USER_W];
    end

    assign user_o[p*USER_W +: USER_W] = user_q;
    assign rdata_o[BASE +: PAIR_STRIDE] =
      {{PAD_W{1'b0}}, user_q, cl_code(timing_cl_i[p]), BT_SEQ, BL_FOUR};

    assert_user_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> user_o[p*USER_W +: USER_W] == $past(wdata_i[BASE+MODE_W +: USER_W]));

    assert_burst_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[BASE +: 4] == {BT_SEQ, BL_FOUR});
  end

endmodule

// File: rtl/mrs_addr_compose.sv
module mrs_addr_compose
  import sdram_mrs_pkg::*;
#(
  parameter int USER_W = 8,
  parameter int ADDR_W = 25
) (
  input  logic [USER_W-1:0] user_i,
  input  logic              timing_bit_i,
  output logic [ADDR_W-1:0] ma_o
);

  localparam int LOW_W = ADDR_W - USER_W - MODE_W;

  assign ma_o = {user_i, cl_code(timing_bit_i), BT_SEQ, BL_FOUR, {LOW_W{1'b0}}};

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int NUM_PAIRS      = 2,
  parameter int BANKS_PER_PAIR = 2,
  parameter int ADDR_W         = 25
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                write_i,
  input  logic                                banks_idle_i,
  input  logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] bank_en_i,
  input  logic [NUM_PAIRS*ADDR_W-1:0]         pair_ma_i,
  output logic [ADDR_W-1:0]                   ma_o,
  output logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] cs_n_o,
  output logic                                ras_n_o,
  output logic                                cas_n_o,
  output logic                                we_n_o,
  output logic                                busy_o,
  output logic                                done_o
);

  localparam int NBANK  = NUM_PAIRS * BANKS_PER_PAIR;
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

  seq_state_e          state_q, state_d;
  logic [PAIR_W-1:0]   pair_q, pair_d;
  logic                pend_q, pend_d;
  logic [ADDR_W-1:0]   ma_q;
  logic [NBANK-1:0]    cs_sel_q;
  logic                load_cmd;
  logic [NBANK-1:0]    pair_mask;

  always_comb begin
    pair_mask = '0;
    pair_mask[pair_q*BANKS_PER_PAIR +: BANKS_PER_PAIR] = '1;
  end

  always_comb begin
    state_d  = state_q;
    pair_d   = pair_q;
    pend_d   = pend_q | write_i;
    load_cmd = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pend_q) begin
        state_d = ST_WAIT;
        pair_d  = '0;
        pend_d  = write_i;
      end
      ST_WAIT: if (banks_idle_i) begin
        state_d  = ST_ISSUE;
        load_cmd = 1'b1;
      end
      ST_ISSUE: begin
        if (pair_q == LAST_PAIR) state_d = ST_DONE;
        else begin
          state_d = ST_WAIT;
          pair_d  = pair_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pair_q   <= '0;
      pend_q   <= 1'b0;
      ma_q     <= '0;
      cs_sel_q <= '0;
    end else begin
      state_q <= state_d;
      pair_q  <= pair_d;
      pend_q  <= pend_d;
      if (load_cmd) begin
        ma_q     <= pair_ma_i[pair_q*ADDR_W +: ADDR_W];
        cs_sel_q <= bank_en_i & pair_mask;
      end
    end
  end

  logic issuing;
  assign issuing = (state_q == ST_ISSUE);

  assign ma_o    = ma_q;
  assign cs_n_o  = issuing ? ~cs_sel_q : '1;
  assign ras_n_o = ~issuing;
  assign cas_n_o = ~issuing;
  assign we_n_o  = ~issuing;
  assign busy_o  = pend_q | (state_q == ST_WAIT) | issuing;
  assign done_o  = (state_q == ST_DONE);

  assert_issue_needs_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> $past(banks_idle_i));

  assert_single_cycle_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |=> ras_n_o);

  assert_strobes_together_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o == cas_n_o) && (cas_n_o == we_n_o));

  assert_mode_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> (ma_o[13:10] == 4'b0010) && (ma_o[9:0] == '0));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_i |=> busy_o);

  assert_pending_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_i && busy_o) |=> busy_o);

  for (genvar b = 0; b < NBANK; b++) begin : g_cs_chk
    assert_cs_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_n_o[b] |-> $past(bank_en_i[b]));
  end

endmodule

// File: rtl/sdram_mrs_issuer.sv
module sdram_mrs_issuer
  import sdram_mrs_pkg::*;
#(
  parameter int NUM_PAIRS      = 2,
  parameter int BANKS_PER_PAIR = 2,
  parameter int USER_W         = 8,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 25
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                reg_we_i,
  input  logic [DATA_W-1:0]                   reg_wdata_i,
  output logic [DATA_W-1:0]                   reg_rdata_o,
  input  logic [NUM_PAIRS-1:0]                timing_cl_i,
  input  logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] bank_en_i,
  input  logic                                banks_idle_i,
  output logic [ADDR_W-1:0]                   ma_o,
  output logic [NUM_PAIRS*BANKS_PER_PAIR-1:0] cs_n_o,
  output logic                                ras_n_o,
  output logic                                cas_n_o,
  output logic                                sdram_we_n_o,
  output logic                                busy_o,
  output logic                                done_o
);

  localparam int PAIR_STRIDE = DATA_W / NUM_PAIRS;

  logic [NUM_PAIRS*USER_W-1:0] user_vals;
  logic [NUM_PAIRS*ADDR_W-1:0] pair_ma;

  mrs_cfg_regs #(
    .NUM_PAIRS  (NUM_PAIRS),
    .USER_W     (USER_W),
    .PAIR_STRIDE(PAIR_STRIDE)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .timing_cl_i(timing_cl_i),
    .user_o     (user_vals),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_compose
    mrs_addr_compose #(
      .USER_W(USER_W),
      .ADDR_W(ADDR_W)
    ) u_compose (
      .user_i      (user_vals[p*USER_W +: USER_W]),
      .timing_bit_i(timing_cl_i[p]),
      .ma_o        (pair_ma[p*ADDR_W +: ADDR_W])
    );
  end

  mrs_seq #(
    .NUM_PAIRS     (NUM_PAIRS),
    .BANKS_PER_PAIR(BANKS_PER_PAIR),
    .ADDR_W        (ADDR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .write_i     (reg_we_i),
    .banks_idle_i(banks_idle_i),
    .bank_en_i   (bank_en_i),
    .pair_ma_i   (pair_ma),
    .ma_o        (ma_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (sdram_we_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[DATA_W-1] && !reg_rdata_o[PAIR_STRIDE-1]);

  assert_cs_only_in_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) |-> !ras_n_o);

endmodule

// File: tb/sdram_mrs_issuer_test.sv
module sdram_mrs_issuer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  localparam logic [31:0] V_WDATA [NV] = '{32'h7F80_7F80, 32'hFFFF_FFFF, 32'h5280_1E00, 32'h008F_400F};
  localparam logic [1:0]  V_TIM   [NV] = '{2'b00, 2'b11, 2'b10, 2'b01};
  localparam logic [3:0]  V_EN    [NV] = '{4'b1111, 4'b0101, 4'b1000, 4'b0000};
  localparam logic [31:0] V_RDATA [NV] = '{32'h7FA2_7FA2, 32'h7FB2_7FB2, 32'h52B2_1E22, 32'h00A2_4032};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  tim = '0;
  logic [3:0]  en = '0;
  logic        idle = 1'b1;
  logic [24:0] ma;
  logic [3:0]  cs_n;
  logic        ras_n, cas_n, swe_n, busy, done;

  int checks = 0;
  int fails = 0;
  int cmd_n = 0;
  logic [24:0] log_ma [64];
  logic [3:0]  log_cs [64];
  logic        log_ok [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mrs_issuer uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .timing_cl_i(tim), .bank_en_i(en), .banks_idle_i(idle),
    .ma_o(ma), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .sdram_we_n_o(swe_n), .busy_o(busy), .done_o(done)
  );

  always @(negedge clk) begin
    if (rst_n && !ras_n && cmd_n < 64) begin
      log_ma[cmd_n] = ma;
      log_cs[cmd_n] = cs_n;
      log_ok[cmd_n] = !cas_n && !swe_n;
      cmd_n = cmd_n + 1;
    end
  end

  function automatic logic [24:0] exp_ma(input logic [7:0] user, input logic t);
    return {user, (t ? 3'b011 : 3'b010), 1'b0, 3'b010, 10'b0};
  endfunction

  function automatic logic [3:0] exp_cs(input logic [3:0] e, input int p);
    logic [3:0] r = 4'hF;
    r[2*p]   = ~e[2*p];
    r[2*p+1] = ~e[2*p+1];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 80; i++) begin
      if (!busy && !done) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    int base;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", rdata, 32'h0022_0022);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 cs_n", {28'b0, cs_n}, 32'hF);
    check("R1 strobes", {29'b0, ras_n, cas_n, swe_n}, 32'h7);

    // table walk: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      tim = V_TIM[v];
      en = V_EN[v];
      idle = 1'b1;
      base = cmd_n;
      w = V_WDATA[v];
      do_write(w);
      check("R9 busy after write", {31'b0, busy}, 32'd1);
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      check("R9 busy low at done", {31'b0, busy}, 32'd0);
      check("R2 R3 R4 rdata", rdata, V_RDATA[v]);
      check("R5 command count", cmd_n - base, 32'd2);
      check("R5 strobes low", {31'b0, log_ok[base] & log_ok[base+1]}, 32'd1);
      check("R7 pair0 address", {7'b0, log_ma[base]}, {7'b0, exp_ma(w[14:7], V_TIM[v][0])});
      check("R7 pair2 address", {7'b0, log_ma[base+1]}, {7'b0, exp_ma(w[30:23], V_TIM[v][1])});
      check("R8 pair0 cs", {28'b0, log_cs[base]}, {28'b0, exp_cs(V_EN[v], 0)});
      check("R8 pair2 cs", {28'b0, log_cs[base+1]}, {28'b0, exp_cs(V_EN[v], 1)});
      @(negedge clk);
      check("R9 done single pulse", {31'b0, done}, 32'd0);
    end

    // R6 wait while banks busy
    tim = 2'b00;
    en = 4'hF;
    idle = 1'b0;
    base = cmd_n;
    do_write(32'h0080_0080);
    repeat (8) @(negedge clk);
    check("R6 no command while not idle", cmd_n - base, 32'd0);
    check("R6 busy while waiting", {31'b0, busy}, 32'd1);
    idle = 1'b1;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    check("R6 commands after idle", cmd_n - base, 32'd2);
    wait_quiet();

    // R10 write during busy is replayed
    base = cmd_n;
    do_write(32'h0100_0100);
    do_write(32'h1180_2200);
    wait_quiet();
    check("R10 command count", cmd_n - base, 32'd4);
    check("R10 replay pair0", {7'b0, log_ma[base+2]}, {7'b0, exp_ma(8'h44, 1'b0)});
    check("R10 replay pair2", {7'b0, log_ma[base+3]}, {7'b0, exp_ma(8'h23, 1'b0)});
    check("R10 busy cleared", {31'b0, busy}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule